// File: doc/BRIEF.md
# DVFS Transition Sequencer

This block moves a design from one operating point to another. An operating point pairs a clock frequency step with a supply voltage code. Software asks for a new frequency step. The block looks up the lowest voltage code that still meets timing at that step. It then drives separate requests to the supply regulator and to the PLL, in an order chosen so that the clock never runs faster than the present supply can support.

Frequency step `f` stands for 200 + 33·f MHz, which covers 200 MHz to 695 MHz with the 4-bit default. Voltage code `v` stands for 1.1 V + v·(0.5/31) V. When the frequency goes up, the supply is raised first and the clock follows once the regulator reports that it has settled. When the frequency goes down, the clock is lowered first and the supply follows once the PLL reports lock at the new rate.

Every wait has a programmable timeout. When a wait times out, the block raises a sticky error flag and returns both requests to the last operating point that completed. Requests that arrive while a transition is running are dropped, and a saturating counter records how many were dropped.

Top module: `dvfs_sequencer`

## Requirements
- R1: After reset, the block is idle with `busy`, `done` and `error` at 0. `pll_code`, `cur_fstep`, `vreg_code` and `cur_vcode` are all 0, and `reject_count` is 0.
- R2: The voltage code paired with frequency step f is ceil(31·f/15), written as (31·f+14)/15. Step 0 maps to code 0, step 15 maps to code 31, and the mapping never decreases as f rises.
- R3: For a higher target step, `vreg_load` pulses first, carrying the new voltage code. `pll_load`, carrying the new step, follows in the cycle after `vreg_settled` is sampled high.
- R4: For a lower target step, `pll_load` pulses first, carrying the new step. `vreg_load`, carrying the new code, follows in the cycle after `pll_locked` is sampled high.
- R5: After the final handshake of a transition, `done` pulses for one cycle. In that same cycle `busy` is low and `cur_fstep` and `cur_vcode` show the target point.
- R6: A request for the current step produces `done` in the next cycle. It causes no `vreg_load` and no `pll_load`, and `busy` stays low.
- R7: A `req_valid` seen while `busy` is high is ignored. It increments `reject_count`, which saturates at 2^REJ_W−1 (15 by default).
- R8: A wait state that sees no handshake within `timeout_limit`+1 cycles sets `error`. It re-issues both requests at the last completed point with `vreg_load` and `pll_load` pulses, and returns to idle. `error` clears when the next transition starts.
- R9: At all times, `vreg_code` is at least the R2 code for the present `pll_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_fstep | input | FSTEP_W | Requested frequency step |
| timeout_limit | input | TMO_W | Wait-state timeout, in cycles |
| vreg_settled | input | 1 | Regulator has reached the requested code |
| pll_locked | input | 1 | PLL has locked at the requested step |
| vreg_code | output | VCODE_W | Voltage code requested from the regulator |
| vreg_load | output | 1 | One-cycle strobe for a new regulator request |
| pll_code | output | FSTEP_W | Frequency step requested from the PLL |
| pll_load | output | 1 | One-cycle strobe for a new PLL request |
| cur_fstep | output | FSTEP_W | Last completed frequency step |
| cur_vcode | output | VCODE_W | Last completed voltage code |
| busy | output | 1 | Transition in progress |
| done | output | 1 | Transition completed (one-cycle pulse) |
| error | output | 1 | Sticky timeout flag |
| reject_count | output | REJ_W | Saturating count of dropped requests |

## Verification
The sequencing is tried with rising moves, falling moves, requests for the current step, and a full sweep of steps followed by jumps between the two extreme steps. Comparing the cycle stamps of the two load strobes separates a correct up-order from a correct down-order. The exact gap between the strobes, set by how long the bench's responder delays its answer, shows that each step really waits for its handshake. A muted regulator during a rise and a muted PLL during a fall reach the two distinct recovery paths, and bursts of requests during a long wait exercise both the dropping of requests and the saturation of the counter.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_V_UP  = 3'd1,
    ST_F_UP  = 3'd2,
    ST_F_DN  = 3'd3,
    ST_V_DN  = 3'd4
  } seq_state_t;

  // Lowest voltage code meeting timing at step f: ceil(f*max_v/max_f)
  function automatic int min_vcode(input int f, input int max_f, input int max_v);
    return (f * max_v + max_f - 1) / max_f;
  endfunction

endpackage

// File: rtl/dvfs_vf_table.sv
module dvfs_vf_table #(
  parameter int FSTEP_W = 4,
  parameter int VCODE_W = 5
) (
  input  logic [FSTEP_W-1:0] fstep,
  output logic [VCODE_W-1:0] vcode
);
  localparam int NSTEPS = 1 << FSTEP_W;
  localparam int MAX_F  = NSTEPS - 1;
  localparam int MAX_V  = (1 << VCODE_W) - 1;

  logic [VCODE_W-1:0] lut [NSTEPS];

  for (genvar i = 0; i < NSTEPS; i++) begin : g_entry
    assign lut[i] = VCODE_W'(dvfs_pkg::min_vcode(i, MAX_F, MAX_V));
  end

  assign vcode = lut[fstep];
endmodule

// File: rtl/dvfs_wait_timer.sv
module dvfs_wait_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q >= limit);
  assign cnt_en  = clear | ~expired;

  always_comb begin
    if (clear) cnt_d = '0;
    else       cnt_d = cnt_q + TMO_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dvfs_sat_counter.sv
module dvfs_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic en;
  assign en = inc & ~(&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  count <= '0;
    else if (en) count <= count + W'(1);
  end
endmodule

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer #(
  parameter int FSTEP_W = 4,
  parameter int VCODE_W = 5,
  parameter int TMO_W   = 8,
  parameter int REJ_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [FSTEP_W-1:0] req_fstep,
  input  logic [TMO_W-1:0]   timeout_limit,
  input  logic               vreg_settled,
  input  logic               pll_locked,
  output logic [VCODE_W-1:0] vreg_code,
  output logic               vreg_load,
  output logic [FSTEP_W-1:0] pll_code,
  output logic               pll_load,
  output logic [FSTEP_W-1:0] cur_fstep,
  output logic [VCODE_W-1:0] cur_vcode,
  output logic               busy,
  output logic               done,
  output logic               error,
  output logic [REJ_W-1:0]   reject_count
);
  import dvfs_pkg::*;

  seq_state_t         state_q, state_d;
  logic [FSTEP_W-1:0] tgt_f_q, tgt_f_d, cur_f_d, pll_d;
  logic [VCODE_W-1:0] tgt_v_q, tgt_v_d, cur_v_d, vreg_d;
  logic               vload_d, pload_d, done_d, err_d;
  logic [VCODE_W-1:0] req_vcode;
  logic               tmr_clear, tmr_expired;

  dvfs_vf_table #(.FSTEP_W(FSTEP_W), .VCODE_W(VCODE_W)) u_table (
    .fstep (req_fstep),
    .vcode (req_vcode)
  );

  dvfs_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (tmr_clear),
    .limit   (timeout_limit),
    .expired (tmr_expired)
  );

  dvfs_sat_counter #(.W(REJ_W)) u_reject (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (req_valid & busy),
    .count (reject_count)
  );

  assign busy      = (state_q != ST_IDLE);
  assign tmr_clear = (state_q == ST_IDLE) | (state_d != state_q);

  always_comb begin
    state_d = state_q;
    tgt_f_d = tgt_f_q;
    tgt_v_d = tgt_v_q;
    cur_f_d = cur_fstep;
    cur_v_d = cur_vcode;
    pll_d   = pll_code;
    vreg_d  = vreg_code;
    vload_d = 1'b0;
    pload_d = 1'b0;
    done_d  = 1'b0;
    err_d   = error;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_fstep == cur_fstep) begin
            done_d = 1'b1;
          end else begin
            err_d   = 1'b0;
            tgt_f_d = req_fstep;
            tgt_v_d = req_vcode;
            if (req_fstep > cur_fstep) begin
              vreg_d  = req_vcode;
              vload_d = 1'b1;
              state_d = ST_V_UP;
            end else begin
              pll_d   = req_fstep;
              pload_d = 1'b1;
              state_d = ST_F_DN;
            end
          end
        end
      end
      ST_V_UP: begin
        if (vreg_settled) begin
          pll_d   = tgt_f_q;
          pload_d = 1'b1;
          state_d = ST_F_UP;
        end
      end
      ST_F_DN: begin
        if (pll_locked) begin
          vreg_d  = tgt_v_q;
          vload_d = 1'b1;
          state_d = ST_V_DN;
        end
      end
      ST_F_UP, ST_V_DN: begin
        if ((state_q == ST_F_UP && pll_locked) ||
            (state_q == ST_V_DN && vreg_settled)) begin
          cur_f_d = tgt_f_q;
          cur_v_d = tgt_v_q;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    // Timeout in any wait state: fall back to the last completed point
    if (busy && state_d == state_q && tmr_expired) begin
      pll_d   = cur_fstep;
      vreg_d  = cur_vcode;
      pload_d = 1'b1;
      vload_d = 1'b1;
      err_d   = 1'b1;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tgt_f_q   <= '0;
      tgt_v_q   <= '0;
      cur_fstep <= '0;
      cur_vcode <= '0;
      pll_code  <= '0;
      vreg_code <= '0;
      vreg_load <= 1'b0;
      pll_load  <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
    end else begin
      state_q   <= state_d;
      tgt_f_q   <= tgt_f_d;
      tgt_v_q   <= tgt_v_d;
      cur_fstep <= cur_f_d;
      cur_vcode <= cur_v_d;
      pll_code  <= pll_d;
      vreg_code <= vreg_d;
      vreg_load <= vload_d;
      pll_load  <= pload_d;
      done      <= done_d;
      error     <= err_d;
    end
  end
endmodule

// File: rtl/dvfs_sequencer_checker.sv
module dvfs_sequencer_checker #(
  parameter int FSTEP_W = 4,
  parameter int VCODE_W = 5,
  parameter int REJ_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               vreg_settled,
  input logic               pll_locked,
  input logic [VCODE_W-1:0] vreg_code,
  input logic               vreg_load,
  input logic [FSTEP_W-1:0] pll_code,
  input logic               pll_load,
  input logic [FSTEP_W-1:0] cur_fstep,
  input logic [VCODE_W-1:0] cur_vcode,
  input logic               busy,
  input logic               done,
  input logic               error,
  input logic [REJ_W-1:0]   reject_count
);
  localparam int MAX_F = (1 << FSTEP_W) - 1;
  localparam int MAX_V = (1 << VCODE_W) - 1;

  logic [VCODE_W-1:0] floor_v;
  assign floor_v = VCODE_W'(dvfs_pkg::min_vcode(int'(pll_code), MAX_F, MAX_V));

  assert_supply_covers_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_code >= floor_v);

  assert_raise_after_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_load && !error && pll_code > $past(pll_code)) |-> $past(vreg_settled));

  assert_lower_after_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vreg_load && !error && vreg_code < $past(vreg_code)) |-> $past(pll_locked));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_commits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && pll_code == cur_fstep && vreg_code == cur_vcode));

  assert_reject_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reject_count != $past(reject_count)) |-> ($past(req_valid) && $past(busy)));

  assert_timeout_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> (!busy && pll_code == cur_fstep && vreg_code == cur_vcode
                      && pll_load && vreg_load));
endmodule

bind dvfs_sequencer dvfs_sequencer_checker #(
  .FSTEP_W(FSTEP_W), .VCODE_W(VCODE_W), .REJ_W(REJ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .vreg_settled(vreg_settled), .pll_locked(pll_locked),
  .vreg_code(vreg_code), .vreg_load(vreg_load),
  .pll_code(pll_code), .pll_load(pll_load),
  .cur_fstep(cur_fstep), .cur_vcode(cur_vcode),
  .busy(busy), .done(done), .error(error), .reject_count(reject_count)
);

// File: tb/dvfs_sequencer_test.sv
module dvfs_sequencer_test;
  localparam int FW = 4, VW = 5, TW = 8, RW = 4;

  logic          clk, rst_n, req_valid, vreg_settled, pll_locked;
  logic [FW-1:0] req_fstep, pll_code, cur_fstep;
  logic [TW-1:0] timeout_limit;
  logic [VW-1:0] vreg_code, cur_vcode;
  logic          vreg_load, pll_load, busy, done, error;
  logic [RW-1:0] reject_count;

  dvfs_sequencer #(.FSTEP_W(FW), .VCODE_W(VW), .TMO_W(TW), .REJ_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fstep(req_fstep),
    .timeout_limit(timeout_limit), .vreg_settled(vreg_settled),
    .pll_locked(pll_locked), .vreg_code(vreg_code), .vreg_load(vreg_load),
    .pll_code(pll_code), .pll_load(pll_load), .cur_fstep(cur_fstep),
    .cur_vcode(cur_vcode), .busy(busy), .done(done), .error(error),
    .reject_count(reject_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0, failed = 0, cyc = 0;
  int v_delay = 3, p_delay = 3;
  logic v_mute = 1'b0, p_mute = 1'b0;
  int v_cnt = 0, p_cnt = 0;
  int v_cyc, p_cyc, v_n, p_n, done_n, busy_n;

  // Regulator and PLL modelled as delayed handshake responders
  always @(posedge clk) begin
    vreg_settled <= 1'b0;
    pll_locked   <= 1'b0;
    if (vreg_load && !v_mute) v_cnt <= v_delay;
    else if (v_cnt == 1) begin vreg_settled <= 1'b1; v_cnt <= 0; end
    else if (v_cnt > 1) v_cnt <= v_cnt - 1;
    if (pll_load && !p_mute) p_cnt <= p_delay;
    else if (p_cnt == 1) begin pll_locked <= 1'b1; p_cnt <= 0; end
    else if (p_cnt > 1) p_cnt <= p_cnt - 1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (vreg_load) begin v_cyc <= cyc; v_n <= v_n + 1; end
    if (pll_load)  begin p_cyc <= cyc; p_n <= p_n + 1; end
    if (done)      done_n <= done_n + 1;
    if (busy)      busy_n <= busy_n + 1;
  end

  function automatic int exp_v(input int f);
    return (31 * f + 14) / 15;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic clear_marks();
    v_n = 0; p_n = 0; done_n = 0; busy_n = 0; v_cyc = -1; p_cyc = -1;
  endtask

  task automatic wait_end(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (done_n > 0 || error) break;
      @(negedge clk);
    end
  endtask

  // Full move with ordering and exact handshake-gap checks
  task automatic move(input int tgt);
    int start_f;
    start_f = int'(cur_fstep);
    clear_marks();
    req_fstep = FW'(tgt); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    wait_end(400);
    @(negedge clk);
    check(done_n == 1, "R5 done pulse", done_n, 1);
    check(int'(pll_code) == tgt && int'(cur_fstep) == tgt, "R5 step", int'(cur_fstep), tgt);
    check(int'(vreg_code) == exp_v(tgt) && int'(cur_vcode) == exp_v(tgt), "R2 vcode",
          int'(vreg_code), exp_v(tgt));
    if (tgt > start_f) begin
      check(v_n == 1 && p_n == 1 && p_cyc - v_cyc == v_delay + 2, "R3 up order gap",
            p_cyc - v_cyc, v_delay + 2);
    end else if (tgt < start_f) begin
      check(v_n == 1 && p_n == 1 && v_cyc - p_cyc == p_delay + 2, "R4 down order gap",
            v_cyc - p_cyc, p_delay + 2);
    end
  endtask

  task automatic t_reset();
    check(!busy && !done && !error, "R1 flags", {busy, done, error}, 0);
    check(pll_code == 0 && cur_fstep == 0, "R1 step", int'(pll_code), 0);
    check(vreg_code == 0 && cur_vcode == 0, "R1 vcode", int'(vreg_code), 0);
    check(reject_count == 0, "R1 rejects", int'(reject_count), 0);
  endtask

  task automatic t_same();
    clear_marks();
    req_fstep = cur_fstep; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check(done == 1'b1, "R6 done next cycle", int'(done), 1);
    repeat (6) @(negedge clk);
    check(v_n == 0 && p_n == 0, "R6 no loads", v_n + p_n, 0);
    check(busy_n == 0, "R6 never busy", busy_n, 0);
  endtask

  task automatic t_sweep();
    for (int f = 1; f < 16; f++) move(f);
    move(0);
    move(15);
    v_delay = 7; p_delay = 9;
    move(4);
    move(11);
    v_delay = 3; p_delay = 3;
  endtask

  task automatic t_reject(input int tgt, input int pulses, input int exp_cnt);
    v_delay = 60;
    clear_marks();
    req_fstep = FW'(tgt); req_valid = 1'b1;
    @(negedge clk);
    req_fstep = 0;
    for (int i = 0; i < pulses; i++) @(negedge clk);
    req_valid = 1'b0;
    wait_end(400);
    @(negedge clk);
    check(int'(reject_count) == exp_cnt, "R7 reject count", int'(reject_count), exp_cnt);
    check(int'(cur_fstep) == tgt, "R7 rejected ignored", int'(cur_fstep), tgt);
    v_delay = 3;
  endtask

  task automatic t_timeout(input int tgt, input bit up);
    int f0, v0;
    f0 = int'(cur_fstep); v0 = int'(cur_vcode);
    timeout_limit = 8'd10;
    if (up) v_mute = 1'b1; else p_mute = 1'b1;
    clear_marks();
    req_fstep = FW'(tgt); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    wait_end(200);
    check(error == 1'b1, "R8 error set", int'(error), 1);
    check(int'(pll_code) == f0, "R8 step restored", int'(pll_code), f0);
    check(int'(vreg_code) == v0, "R8 vcode restored", int'(vreg_code), v0);
    repeat (3) @(negedge clk);
    check(!busy && done_n == 0, "R8 idle no done", done_n, 0);
    v_mute = 1'b0; p_mute = 1'b0;
    repeat (8) @(negedge clk);
    timeout_limit = 8'd100;
    move(tgt);
    check(error == 1'b0, "R8 error cleared", int'(error), 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_fstep = '0; timeout_limit = 8'd100;
    clear_marks();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_same();
    t_sweep();
    t_same();
    t_reject(13, 5, 5);
    t_reject(2, 20, 15);
    t_timeout(9, 1'b1);
    t_timeout(3, 1'b0);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule